// File: doc/BRIEF.md
# Triggered Sample Playback Controller

This block decides, per channel, when a stream of stored samples is sent toward a converter. Each channel drives a read enable and a read address into its own sample buffer, and a valid strobe that travels one cycle behind the read enable, so that it lines up with the buffer's registered read data. The controller never carries sample data itself.

Each channel has two trigger sources. One is an asynchronous external pin that counts on its rising edge. The other is a single-cycle strobe from a host command decoder. A setup word gives the channel a play mode and a sample count. Four modes are offered: start/stop toggling, single fixed-length bursts, free-running cycling that ignores triggers, and a triggered start that then repeats the programmed samples without end. The number of channels is a parameter. Each channel has its own sequencer and runs independently of the others.

Top module: `tpc_top`

## Requirements
- R1: After reset every channel is idle with mode 2'b00 (toggle) and length field 0: rd_en and out_valid low, rd_addr zero.
- R2: A channel's trigger is either a one-cycle high on cmd_trig, which acts at the next clock edge, or a rising edge on ext_trig. ext_trig passes through two synchronising flops and an edge detector, so an idle channel shows rd_en high after the third clock edge that follows the rise. A level held high gives only one trigger.
- R3: A high cfg_load at a clock edge loads mode (cfg_mode slice, 2 bits) and length (cfg_len slice). The length field holds the sample count minus one. The load resets the address to 0 and leaves the channel idle. The exception is mode 2'b10, which starts playing at once.
- R4: While active, rd_en is high. rd_addr is 0 in the first active cycle, rises by 1 each cycle, and wraps from the length field back to 0. While idle, rd_addr is 0.
- R5: In burst mode 2'b01, a trigger makes exactly length+1 reads at addresses 0 through length, and then the channel goes idle.
- R6: In toggle mode 2'b00, a trigger while idle starts cycling play, and a trigger while active stops it at the next edge.
- R7: In continuous mode 2'b10, the channel cycles without a break from the load onward, and both trigger sources have no effect.
- R8: In burst-loop mode 2'b11, a trigger starts play of the length+1 samples, which then repeat forever. Later triggers neither stop play nor restart the address.
- R9: A trigger that arrives while a burst-mode channel is active is ignored, so the burst still makes exactly length+1 reads.
- R10: out_valid equals the channel's rd_en from the previous cycle.
- R11: The channels are independent. Triggers and loads on one channel leave the outputs of the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_trig | input | NCH | Asynchronous external trigger per channel, rising edge |
| cmd_trig | input | NCH | One-cycle trigger strobe per channel from the command decoder |
| cfg_load | input | NCH | Setup load strobe per channel |
| cfg_mode | input | 2*NCH | Play mode per channel: 00 toggle, 01 burst, 10 continuous, 11 burst-loop |
| cfg_len | input | AW*NCH | Sample count minus one, per channel |
| rd_en | output | NCH | Buffer read enable per channel |
| rd_addr | output | AW*NCH | Buffer read address per channel |
| out_valid | output | NCH | Output path valid strobe, one cycle after rd_en |

## Verification
Each mode is driven with a trigger pattern that separates it from the others. A single strobe ends after length+1 reads in burst mode, but keeps running in toggle and burst-loop modes. A second strobe stops toggle mode, is ignored by burst and burst-loop modes, and does nothing at all in continuous mode. The external pin is driven as a held level and checked cycle by cycle, which shows the two-flop latency and proves that only the rising edge counts. The address sequence and the one-cycle lag of the valid strobe are compared against a running model on every sampled cycle. While channel 0 is being exercised, channel 1 is kept idle to show that the channels do not affect each other.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  typedef enum logic [1:0] {
    PM_TOGGLE = 2'b00,
    PM_BURST  = 2'b01,
    PM_CONT   = 2'b10,
    PM_LOOP   = 2'b11
  } play_mode_t;
endpackage

// File: rtl/tpc_edge_sync.sv
// Two-flop synchroniser followed by a rising-edge detector.
module tpc_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= async_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;
endmodule

// File: rtl/tpc_chan.sv
// Per-channel play sequencer: setup register, run flag, address counter.
module tpc_chan
  import tpc_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic          cfg_load,
  input  logic [1:0]    cfg_mode,
  input  logic [AW-1:0] cfg_len,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          out_valid
);
  play_mode_t    mode_q, mode_d;
  logic [AW-1:0] len_q, len_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          run_q, run_d;
  logic          val_q;
  logic          cfg_en, seq_en;
  logic          at_end;
  logic [AW-1:0] addr_wrap;

  assign at_end    = (addr_q == len_q);
  assign addr_wrap = at_end ? '0 : addr_q + 1'b1;
  assign cfg_en    = cfg_load;
  assign seq_en    = cfg_load | trig | run_q;

  always_comb begin
    mode_d = mode_q;
    len_d  = len_q;
    run_d  = run_q;
    addr_d = addr_q;
    if (cfg_load) begin
      mode_d = play_mode_t'(cfg_mode);
      len_d  = cfg_len;
      run_d  = (play_mode_t'(cfg_mode) == PM_CONT);
      addr_d = '0;
    end else begin
      unique case (mode_q)
        PM_TOGGLE: begin
          if (trig) begin
            run_d  = ~run_q;
            addr_d = '0;
          end else if (run_q) begin
            addr_d = addr_wrap;
          end
        end
        PM_BURST: begin
          if (run_q) begin
            run_d  = ~at_end;
            addr_d = addr_wrap;
          end else if (trig) begin
            run_d  = 1'b1;
            addr_d = '0;
          end
        end
        PM_CONT: begin
          if (run_q) addr_d = addr_wrap;
        end
        PM_LOOP: begin
          if (run_q) begin
            addr_d = addr_wrap;
          end else if (trig) begin
            run_d  = 1'b1;
            addr_d = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PM_TOGGLE;
      len_q  <= '0;
    end else if (cfg_en) begin
      mode_q <= mode_d;
      len_q  <= len_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      addr_q <= '0;
    end else if (seq_en) begin
      run_q  <= run_d;
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= 1'b0;
    else        val_q <= run_q;
  end

  assign rd_en     = run_q;
  assign rd_addr   = addr_q;
  assign out_valid = val_q;
endmodule

// File: rtl/tpc_top.sv
module tpc_top
  import tpc_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    ext_trig,
  input  logic [NCH-1:0]    cmd_trig,
  input  logic [NCH-1:0]    cfg_load,
  input  logic [2*NCH-1:0]  cfg_mode,
  input  logic [AW*NCH-1:0] cfg_len,
  output logic [NCH-1:0]    rd_en,
  output logic [AW*NCH-1:0] rd_addr,
  output logic [NCH-1:0]    out_valid
);
  localparam int MW = $bits(play_mode_t);

  logic [NCH-1:0] ext_rise;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tpc_edge_sync u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (ext_trig[i]),
      .rise     (ext_rise[i])
    );

    tpc_chan #(.AW(AW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig      (ext_rise[i] | cmd_trig[i]),
      .cfg_load  (cfg_load[i]),
      .cfg_mode  (cfg_mode[MW*i +: MW]),
      .cfg_len   (cfg_len[AW*i +: AW]),
      .rd_en     (rd_en[i]),
      .rd_addr   (rd_addr[AW*i +: AW]),
      .out_valid (out_valid[i])
    );
  end
endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
  parameter int NCH = 2,
  parameter int AW  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    cfg_load,
  input logic [2*NCH-1:0]  cfg_mode,
  input logic [NCH-1:0]    rd_en,
  input logic [AW*NCH-1:0] rd_addr,
  input logic [NCH-1:0]    out_valid
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    a_r10_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en[i] |=> out_valid[i]);
    a_r10_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en[i] |=> !out_valid[i]);
    a_r4_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_en[i]) |-> (rd_addr[AW*i +: AW] == '0));
    a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en[i] |-> (rd_addr[AW*i +: AW] == '0));
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en[i] && $past(rd_en[i]) && rd_addr[AW*i +: AW] != '0)
        |-> (rd_addr[AW*i +: AW] == $past(rd_addr[AW*i +: AW]) + 1'b1));
    a_r3_cont_start: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_load[i] && cfg_mode[2*i +: 2] == 2'b10) |=> rd_en[i]);
    a_r3_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_load[i] && cfg_mode[2*i +: 2] != 2'b10) |=> !rd_en[i]);
  end
endmodule

bind tpc_top tpc_checker #(.NCH(NCH), .AW(AW)) u_tpc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_load  (cfg_load),
  .cfg_mode  (cfg_mode),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .out_valid (out_valid)
);

// File: tb/tb_tpc_top.sv
`timescale 1ns/1ps
module tb_tpc_top;
  localparam int NCH = 2;
  localparam int AW  = 6;

  logic              clk;
  logic              rst_n;
  logic [NCH-1:0]    ext_trig;
  logic [NCH-1:0]    cmd_trig;
  logic [NCH-1:0]    cfg_load;
  logic [2*NCH-1:0]  cfg_mode;
  logic [AW*NCH-1:0] cfg_len;
  logic [NCH-1:0]    rd_en;
  logic [AW*NCH-1:0] rd_addr;
  logic [NCH-1:0]    out_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  tpc_top #(.NCH(NCH), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ext_trig(ext_trig), .cmd_trig(cmd_trig),
    .cfg_load(cfg_load), .cfg_mode(cfg_mode), .cfg_len(cfg_len),
    .rd_en(rd_en), .rd_addr(rd_addr), .out_valid(out_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Expected length field per channel, kept by the bench.
  int blen [NCH];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Walk n cycles on channel ch against the address/valid model; counts reads.
  task automatic watch(input int ch, input int n, input string req, output int cnt);
    logic          prd;
    logic [AW-1:0] pad;
    int            expa;
    cnt = 0;
    prd = rd_en[ch];
    pad = rd_addr[AW*ch +: AW];
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(out_valid[ch] === prd, {req, "/R10 valid lag"}, out_valid[ch], prd);
      if (rd_en[ch] === 1'b1) begin
        cnt++;
        expa = !prd ? 0 : ((int'(pad) == blen[ch]) ? 0 : int'(pad) + 1);
      end else begin
        expa = 0;
      end
      check(int'(rd_addr[AW*ch +: AW]) == expa, {req, "/R4 addr"},
            rd_addr[AW*ch +: AW], expa);
      prd = rd_en[ch];
      pad = rd_addr[AW*ch +: AW];
    end
  endtask

  task automatic setup(input int ch, input logic [1:0] m, input int len);
    int c;
    cfg_load[ch] = 1'b1;
    cfg_mode[2*ch +: 2] = m;
    cfg_len[AW*ch +: AW] = AW'(len);
    blen[ch] = len;
    watch(ch, 1, "R3", c);
    cfg_load[ch] = 1'b0;
    check(rd_en[ch] === (m == 2'b10), "R3 run after load", rd_en[ch], (m == 2'b10));
  endtask

  task automatic cmd_pulse(input int ch, input string req, output int c);
    cmd_trig[ch] = 1'b1;
    watch(ch, 1, req, c);
    cmd_trig[ch] = 1'b0;
  endtask

  task automatic t_reset();
    check(rd_en === '0, "R1 rd_en", rd_en, 0);
    check(out_valid === '0, "R1 out_valid", out_valid, 0);
    check(rd_addr === '0, "R1 rd_addr", rd_addr, 0);
  endtask

  task automatic t_burst_cmd();
    int a, b, c1;
    setup(0, 2'b01, 4);
    cmd_pulse(0, "R5", a);
    watch(0, 20, "R5", b);
    check(a + b == 5, "R5 burst length", a + b, 5);
    check(rd_en[0] === 1'b0, "R5 idle after burst", rd_en[0], 0);
    check(rd_en[1] === 1'b0 && rd_addr[AW +: AW] == '0, "R11 other channel idle",
          rd_en[1], 0);
    watch(1, 1, "R11", c1);
  endtask

  task automatic t_ext_burst();
    int c, tot;
    setup(1, 2'b01, 2);
    ext_trig[1] = 1'b1;
    watch(1, 1, "R2", c); check(c == 0, "R2 ext edge 1", c, 0);
    watch(1, 1, "R2", c); check(c == 0, "R2 ext edge 2", c, 0);
    watch(1, 1, "R2", c); check(c == 1, "R2 ext edge 3", c, 1);
    tot = c;
    watch(1, 25, "R2", c);
    tot += c;
    check(tot == 3, "R2 held level one trigger", tot, 3);
    ext_trig[1] = 1'b0;
    watch(1, 4, "R2", c);
  endtask

  task automatic t_retrig();
    int a, b, c, d;
    setup(0, 2'b01, 7);
    cmd_pulse(0, "R9", a);
    watch(0, 2, "R9", b);
    cmd_pulse(0, "R9", c);
    watch(0, 20, "R9", d);
    check(a + b + c + d == 8, "R9 retrigger ignored", a + b + c + d, 8);
  endtask

  task automatic t_toggle();
    int a, b, c, d;
    setup(0, 2'b00, 3);
    cmd_pulse(0, "R6", a);
    watch(0, 12, "R6", b);
    check(a + b == 13, "R6 runs until next trigger", a + b, 13);
    cmd_pulse(0, "R6", c);
    check(c == 0, "R6 stop", c, 0);
    watch(0, 10, "R6", d);
    check(d == 0, "R6 stays stopped", d, 0);
  endtask

  task automatic t_cont();
    int a, b, c, d;
    setup(0, 2'b10, 5);
    watch(0, 8, "R7", a);
    cmd_pulse(0, "R7", b);
    ext_trig[0] = 1'b1;
    watch(0, 6, "R7", c);
    ext_trig[0] = 1'b0;
    watch(0, 6, "R7", d);
    check(a + b + c + d == 21, "R7 triggers ignored", a + b + c + d, 21);
  endtask

  task automatic t_loop();
    int a, b, c, d;
    setup(0, 2'b11, 3);
    watch(0, 5, "R8", a);
    check(a == 0, "R8 waits for trigger", a, 0);
    cmd_pulse(0, "R8", b);
    watch(0, 9, "R8", c);
    cmd_pulse(0, "R8", d);
    watch(0, 9, "R8", a);
    check(b + c + d + a == 20, "R8 loops forever", b + c + d + a, 20);
    setup(0, 2'b01, 3);
    check(rd_en[0] === 1'b0, "R3 load stops play", rd_en[0], 0);
  endtask

  initial begin
    rst_n = 1'b0; ext_trig = '0; cmd_trig = '0; cfg_load = '0;
    cfg_mode = '0; cfg_len = '0;
    for (int i = 0; i < NCH; i++) blen[i] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_burst_cmd();
    t_ext_burst();
    t_retrig();
    t_toggle();
    t_cont();
    t_loop();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule